// File: doc/BRIEF.md
# Dual-Mode Serial I/O Unit

This unit is the serial port of a small 4-bit controller core. It holds one 4-bit register that works in one of two modes. In shift mode the register moves left once per instruction cycle and takes the serial input into its low bit. In counter mode the register counts down once for each high-to-low transition seen on the serial input. The controller moves data in and out of the register with an exchange command. That command swaps the register with the accumulator and also latches the carry bit.

A 4-bit enable register selects the mode. It also controls the serial output, and it gives the enable for an external 8-bit parallel port. A carry latch, loaded by the exchange command, gates the clock/strobe output. In shift mode that output pulses with the instruction-cycle strobe. In counter mode it shows the latch level directly. The serial input is synchronised with two flops, and in counter mode its edges are detected at the instruction-cycle rate. Every event happens on the system clock. Shifts and counts happen only in cycles where the instruction strobe is high.

Top module: `serial_io_unit`

## Requirements
- R1: After a synchronous reset, the following are all 0: the register, the enable register and the carry latch. The unit is then in shift mode with `so`=0, `sk`=0, `acc_out`=0 and `par_oe`=0.
- R2: In shift mode (enable bit 0 = 0), each clock with `cyc_stb`=1 shifts the register left by one place. The synchronised `si` level enters bit 0. `si` must be held for two clocks before the strobe edge.
- R3: In counter mode (enable bit 0 = 1), the register decrements by one at the first strobe after `si` goes from 1 to 0. Each low and high phase of `si` must span at least two strobes.
- R4: When the counter decrements from 0, it wraps to 15.
- R5: In counter mode, `so` equals enable bit 3.
- R6: In shift mode, `so` equals the register's bit 3 when enable bit 3 is 1. When enable bit 3 is 0, `so` is 0 and shifting still continues.
- R7: In counter mode, `sk` equals the carry latch. In shift mode, `sk` equals the carry latch ANDed with `cyc_stb`.
- R8: `acc_out` always shows the register contents. On a clock with `xchg`=1, the register loads `acc_in` and the carry latch loads `carry_in`.
- R9: When `xchg` and a shift or count fall in the same clock, the exchanged value is stored and that step is skipped. A pending `si` falling edge is consumed and does not cause a later decrement.
- R10: On a clock with `en_load`=1, the enable register loads `en_data`. Enable bit 1 has no effect on any output.
- R11: `par_oe` equals enable bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_stb | input | 1 | Instruction-cycle strobe, one clock wide |
| si | input | 1 | Serial input (asynchronous) |
| so | output | 1 | Serial output |
| sk | output | 1 | Clock/strobe output |
| en_load | input | 1 | Load the enable register |
| en_data | input | 4 | New enable register value |
| xchg | input | 1 | Exchange register with accumulator |
| acc_in | input | W | Accumulator value written into the register |
| carry_in | input | 1 | Carry bit copied into the carry latch on exchange |
| acc_out | output | W | Register contents returned to the accumulator |
| par_oe | output | 1 | Output enable for the 8-bit parallel port |

## Verification
An exchange can land in the same clock as a shift step, or as a counter decrement. The bench provokes both cases by raising `xchg` in the strobe cycle. In counter mode it first settles `si` low, so a falling edge is pending at that strobe. The result is judged from `acc_out`. It must equal the exchanged value exactly, and it must not move on the following strobes while `si` stays low. A later full pulse must then decrement it by exactly one.

// File: rtl/serial_io_unit.sv
module serial_io_unit #(
  parameter int W    = 4,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cyc_stb,
  input  logic         si,
  output logic         so,
  output logic         sk,
  input  logic         en_load,
  input  logic [3:0]   en_data,
  input  logic         xchg,
  input  logic [W-1:0] acc_in,
  input  logic         carry_in,
  output logic [W-1:0] acc_out,
  output logic         par_oe
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [SYNC-1:0] sync_q;
  logic            si_prev;
  logic [W-1:0]    sio_q;
  logic [3:0]      en_q;
  logic            skl;

  wire si_s       = sync_q[SYNC-1];
  wire count_mode = en_q[0];
  wire si_fall    = si_prev & ~si_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '0;
      si_prev <= 1'b0;
      sio_q   <= '0;
      en_q    <= '0;
      skl     <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], si};
      if (cyc_stb) si_prev <= si_s;
      if (en_load) en_q <= en_data;
      if (xchg) begin
        sio_q <= acc_in;
        skl   <= carry_in;
      end else if (cyc_stb) begin
        if (!count_mode) sio_q <= {sio_q[W-2:0], si_s};
        else if (si_fall) sio_q <= sio_q - ONE;
      end
    end
  end

  assign so      = count_mode ? en_q[3] : (en_q[3] & sio_q[W-1]);
  assign sk      = skl & (count_mode | cyc_stb);
  assign acc_out = sio_q;
  assign par_oe  = en_q[2];
endmodule

module serial_io_unit_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         cyc_stb,
  input logic         xchg,
  input logic [W-1:0] acc_in,
  input logic         carry_in,
  input logic [W-1:0] sio_q,
  input logic [3:0]   en_q,
  input logic         skl,
  input logic         si_prev,
  input logic         si_s,
  input logic         so,
  input logic         sk
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (sio_q == '0 && en_q == 4'd0 && !skl));

  p_shift_step_r2: assert property (@(posedge clk) disable iff (rst)
    (cyc_stb && !xchg && !en_q[0]) |=> sio_q[W-1:1] == $past(sio_q[W-2:0]));

  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (cyc_stb && !xchg && en_q[0] && si_prev && !si_s) |=> sio_q == $past(sio_q) - W'(1));

  p_so_off_r6: assert property (@(posedge clk) disable iff (rst)
    (!en_q[0] && !en_q[3]) |-> !so);

  p_sk_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (!en_q[0] && !cyc_stb) |-> !sk);

  p_xchg_r8: assert property (@(posedge clk) disable iff (rst)
    xchg |=> (sio_q == $past(acc_in) && skl == $past(carry_in)));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!cyc_stb && !xchg) |=> $stable(sio_q));
endmodule

bind serial_io_unit serial_io_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .xchg(xchg), .acc_in(acc_in),
  .carry_in(carry_in), .sio_q(sio_q), .en_q(en_q), .skl(skl),
  .si_prev(si_prev), .si_s(si_s), .so(so), .sk(sk)
);

// File: tb/serial_io_unit_bench.sv
module serial_io_unit_bench;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_stb = 1'b0, si = 1'b1, en_load = 1'b0, xchg = 1'b0, carry_in = 1'b0;
  logic [3:0] en_data = 4'd0;
  logic [W-1:0] acc_in = '0;
  logic so, sk, par_oe;
  logic [W-1:0] acc_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_io_unit #(.W(W)) u_serial_io_unit (
    .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .si(si), .so(so), .sk(sk),
    .en_load(en_load), .en_data(en_data), .xchg(xchg), .acc_in(acc_in),
    .carry_in(carry_in), .acc_out(acc_out), .par_oe(par_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic instr();
    repeat (2) @(negedge clk);
    cyc_stb = 1'b1;
    @(negedge clk);
    cyc_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic load_en(input logic [3:0] e);
    @(negedge clk);
    en_load = 1'b1; en_data = e;
    @(negedge clk);
    en_load = 1'b0;
  endtask

  task automatic do_xchg(input logic [W-1:0] v, input logic c);
    @(negedge clk);
    xchg = 1'b1; acc_in = v; carry_in = c;
    @(negedge clk);
    xchg = 1'b0;
  endtask

  task automatic pulse();
    si = 1'b0; instr(); instr();
    si = 1'b1; instr(); instr();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(so == 0 && sk == 0, "R1 so/sk", {so, sk}, 0);
    check(acc_out == 0, "R1 acc_out", acc_out, 0);
    check(par_oe == 0, "R1 par_oe", par_oe, 0);

    // R2: shift sweep over every start value and 4-bit serial pattern
    load_en(4'b0000);
    for (int v = 0; v < 16; v++) begin
      for (int p = 0; p < 16; p++) begin
        int exp;
        do_xchg(W'(v), 1'b0);
        exp = v;
        for (int k = 3; k >= 0; k--) begin
          si = p[k];
          instr();
          exp = ((exp << 1) | p[k]) & 15;
          check(acc_out == W'(exp), "R2 shift", acc_out, exp);
          check(so == 0, "R6 so off", so, 0);
        end
      end
    end

    // R6: so follows msb when enable bit 3 set
    load_en(4'b1000);
    do_xchg(4'b1010, 1'b0);
    check(so == 1, "R6 so msb", so, 1);
    si = 1'b0; instr();
    check(so == 0, "R6 so msb after shift", so, 0);
    instr();
    check(so == 1, "R6 so msb after 2 shifts", so, 1);

    // R10: enable bit 1 changes nothing
    load_en(4'b1010);
    do_xchg(4'b0110, 1'b0);
    si = 1'b1; instr();
    check(acc_out == 4'b1101 && so == 1, "R10 bit1 shift", {so, acc_out}, 5'b11101);
    check(par_oe == 0, "R10 bit1 par_oe", par_oe, 0);

    // R11
    load_en(4'b0100);
    check(par_oe == 1, "R11 par_oe set", par_oe, 1);

    // R7 shift mode
    load_en(4'b0000);
    do_xchg(4'd0, 1'b1);
    check(sk == 0, "R7 sk idle shift", sk, 0);
    @(negedge clk); cyc_stb = 1'b1; #1;
    check(sk == 1, "R7 sk strobe shift", sk, 1);
    @(negedge clk); cyc_stb = 1'b0; #1;
    check(sk == 0, "R7 sk after strobe", sk, 0);
    do_xchg(4'd0, 1'b0);
    @(negedge clk); cyc_stb = 1'b1; #1;
    check(sk == 0, "R7 sk latch 0", sk, 0);
    @(negedge clk); cyc_stb = 1'b0;

    // R5 / R7 counter mode
    si = 1'b1;
    load_en(4'b1001);
    check(so == 1, "R5 so=en3", so, 1);
    load_en(4'b0001);
    check(so == 0, "R5 so=en3 clear", so, 0);
    do_xchg(4'd3, 1'b1);
    check(sk == 1, "R7 sk counter", sk, 1);
    do_xchg(4'd3, 1'b0);
    check(sk == 0, "R7 sk counter 0", sk, 0);

    // R3 / R4: counter sweep
    instr(); instr();
    for (int v = 0; v < 16; v++) begin
      for (int n = 0; n <= 5; n++) begin
        do_xchg(W'(v), 1'b0);
        for (int j = 0; j < n; j++) pulse();
        check(acc_out == W'((v - n) & 15), (v < n) ? "R4 wrap" : "R3 count",
              acc_out, (v - n) & 15);
      end
    end

    // R9 collision in shift mode
    load_en(4'b0000);
    do_xchg(4'd5, 1'b0);
    si = 1'b1;
    repeat (2) @(negedge clk);
    cyc_stb = 1'b1; xchg = 1'b1; acc_in = 4'd9;
    @(negedge clk);
    cyc_stb = 1'b0; xchg = 1'b0;
    check(acc_out == 9, "R9 xchg beats shift", acc_out, 9);

    // R9 collision in counter mode with pending falling edge
    load_en(4'b0001);
    si = 1'b1; instr(); instr();
    do_xchg(4'd7, 1'b0);
    si = 1'b0;
    repeat (2) @(negedge clk);
    cyc_stb = 1'b1; xchg = 1'b1; acc_in = 4'd10;
    @(negedge clk);
    cyc_stb = 1'b0; xchg = 1'b0;
    check(acc_out == 10, "R9 xchg beats count", acc_out, 10);
    instr(); instr();
    check(acc_out == 10, "R9 edge consumed", acc_out, 10);
    si = 1'b1; instr(); instr();
    pulse();
    check(acc_out == 9, "R9 next pulse counts", acc_out, 9);

    // R1 reset mid-run
    load_en(4'b1101);
    do_xchg(4'd6, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(so == 0 && sk == 0, "R1 reset so/sk", {so, sk}, 0);
    check(acc_out == 0 && par_oe == 0, "R1 reset state", {par_oe, acc_out}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1 (timeout)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule